// File: doc/BRIEF.md
# Decoded Block Buffer with Read Request

This block sits between a radio data decoder and a host controller. The decoder hands over one decoded block at a time: 16 data bits, an error-correction count, the sync state at reception, a tone-detect flag, a 3-bit offset type and an offset-detected flag. The block keeps up to `DEPTH` (24) such blocks in arrival order. A write filter decides which blocks are kept. Unsynchronized blocks are dropped unless the keep-unsynced control is set.

The host reads 32-bit words while its chip-select is high. It advances one bit per `rd_shift` pulse, and the block presents the current word in parallel and as the current bit. Each word carries the oldest block together with a coarse fill level and a flag that says whether another block follows. When nothing is stored, the word is all zeros. A word read only partly is offered again on the next read.

An active-low request line tells the host that data waits. After every read it is held off for a fixed number of cycles. A sync reset empties the store. Blocks that arrive while sync is being captured are held back, and they become readable and counted once sync is reported. When the store is full, a new block replaces the oldest one.

Top module: `blkbuf_top`

## Requirements
- R1: Stored blocks are read out oldest first, and up to DEPTH (24) blocks are held.
- R2: A word for a stored block is, from bit 31 down: data[15:0] in bits 31:16, error count in 15:13, block sync flag in 12, tone flag in 11, fill code in 10:9, more-data flag in 8, offset type in 7:5, offset-detected in 4, and the constant 1010 in 3:0. Bit 31 is delivered first.
- R3: The fill code counts readable blocks including the one being delivered: 00 for 1 to 7, 01 for 8 to 15, 10 for 16 to 23 and 11 for 24. The more-data flag is 1 when at least two readable blocks exist and 0 otherwise.
- R4: With no readable block, every word read is 32 zero bits, and reading such words removes nothing.
- R5: While chip-select is high and no shift arrives, the word being read stays fixed. If chip-select falls after 1 to 30 bits, nothing is removed and the next read starts that same word again. If it falls after exactly 31 bits, the block counts as read.
- R6: After the 32nd shift of a word, that block is removed and the next stored block is offered at once, without chip-select falling.
- R7: `req_n` goes low one cycle after any cycle in which readable data exists, chip-select is low and the hold-off has expired. It is high while chip-select is high, and for HOLD_CYC cycles after each falling edge of chip-select.
- R8: Outside capture, a block with `blk_insync`=0 is stored only if `keep_unsync`=1. A block with `blk_insync`=1 is always stored.
- R9: `sync_rst` empties the store. From its release until `sync_now` is seen high, every incoming block is kept but stays unreadable: the word is zero and `req_n` stays high. When `sync_now` is seen, those blocks become readable and are counted in the fill code.
- R10: A block written while DEPTH blocks are held removes the oldest one.
- R11: After reset the store is empty, `rd_word` is zero and `req_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| blk_valid | input | 1 | One-cycle strobe: a decoded block is offered |
| blk_data | input | 16 | Decoded data bits |
| blk_err | input | 3 | Bits corrected (0-5) or 6 for uncorrectable |
| blk_insync | input | 1 | Block was received while in sync |
| blk_tone | input | 1 | Tone-detect flag for the block |
| blk_otype | input | 3 | Offset type code |
| blk_odet | input | 1 | Offset word was detected |
| keep_unsync | input | 1 | Also store blocks received out of sync |
| sync_rst | input | 1 | Sync reset, active high, empties the store |
| sync_now | input | 1 | Decoder currently reports sync (ends capture) |
| rd_cs | input | 1 | Host chip-select, read active while high |
| rd_shift | input | 1 | One pulse per bit consumed by the host |
| rd_word | output | 32 | Word currently being delivered |
| rd_bit | output | 1 | Bit currently presented (MSB first) |
| req_n | output | 1 | Active-low read request |

## Verification
The bench aims at the resume rule. It stops after 10 bits and after exactly 31 bits: a design that miscounts the last bit would either lose a block or deliver it twice. It fills the store past full and checks that the two oldest blocks behind the committed ones are gone and that the fill code reads 11. A wrong overwrite would show a stale head or a wrong fill code. After a sync reset it stores blocks during capture and checks that they stay hidden until sync is reported, so a design that counted them early would raise the request line too soon. It also times the request hold-off against chip-select, and it reads past the end of the store to check that empty reads give zeros and remove nothing.

// File: rtl/blkbuf_pkg.sv
package blkbuf_pkg;

    localparam int WORD_W    = 32;
    localparam int FILL_STEP = 8;

    typedef struct packed {
        logic [15:0] data;
        logic [2:0]  err;
        logic        insync;
        logic        tone;
        logic [2:0]  otype;
        logic        odet;
    } blk_t;

    // coarse occupancy code, saturating at 3
    function automatic logic [1:0] fill_code(input int unsigned vis);
        int unsigned step;
        step = vis / FILL_STEP;
        return (step >= 3) ? 2'd3 : 2'(step);
    endfunction

    // output word for the head block given the readable count
    function automatic logic [WORD_W-1:0] build_word(input blk_t e, input int unsigned vis);
        logic more;
        if (vis == 0) return '0;
        more = (vis >= 2);
        return {e.data, e.err, e.insync, e.tone, fill_code(vis), more,
                e.otype, e.odet, 4'b1010};
    endfunction

endpackage

// File: rtl/blkbuf_store.sv
module blkbuf_store
    import blkbuf_pkg::*;
#(
    parameter int DEPTH = 24,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  blk_t          wr_blk,
    input  logic [AW-1:0] rd_addr,
    output blk_t          rd_blk
);

    blk_t cells [DEPTH];

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_cell
            blk_t cell_d, cell_q;
            always_comb begin
                cell_d = cell_q;
                if (wr_en && (wr_addr == AW'(i))) cell_d = wr_blk;
            end
            always_ff @(posedge clk) begin
                cell_q <= cell_d;
            end
            assign cells[i] = cell_q;
        end
    endgenerate

    assign rd_blk = cells[rd_addr];

    // R1
    wr_addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_addr < AW'(DEPTH)));

    // R1
    rd_addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_addr < AW'(DEPTH));

endmodule

// File: rtl/blkbuf_occ.sv
module blkbuf_occ #(
    parameter int DEPTH = 24,
    parameter int AW    = $clog2(DEPTH),
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          blk_valid,
    input  logic          blk_insync,
    input  logic          keep_unsync,
    input  logic          sync_rst,
    input  logic          sync_now,
    input  logic          pop,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [AW-1:0] rd_addr,
    output logic [CW-1:0] vis_cnt,
    output logic          head_drop
);

    typedef struct packed {
        logic [AW-1:0] head;
        logic [AW-1:0] tail;
        logic [CW-1:0] total;
        logic [CW-1:0] pend;
        logic          capture;
    } occ_t;

    occ_t occ_d, occ_q;
    logic store;

    function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] a);
        return (a == AW'(DEPTH - 1)) ? '0 : a + 1'b1;
    endfunction

    always_comb begin
        occ_d     = occ_q;
        head_drop = 1'b0;
        wr_en     = 1'b0;
        store     = blk_valid && (occ_q.capture || blk_insync || keep_unsync);
        if (sync_rst) begin
            occ_d.head    = '0;
            occ_d.tail    = '0;
            occ_d.total   = '0;
            occ_d.pend    = '0;
            occ_d.capture = 1'b1;
        end else begin
            if (pop) begin
                occ_d.head  = wrap_inc(occ_d.head);
                occ_d.total = occ_d.total - 1'b1;
            end
            if (store) begin
                wr_en = 1'b1;
                if (occ_d.total == CW'(DEPTH)) begin
                    if (occ_d.total != occ_d.pend) head_drop = 1'b1;
                    else occ_d.pend = occ_d.pend - 1'b1;
                    occ_d.head  = wrap_inc(occ_d.head);
                    occ_d.total = occ_d.total - 1'b1;
                end
                occ_d.tail  = wrap_inc(occ_d.tail);
                occ_d.total = occ_d.total + 1'b1;
                if (occ_q.capture) occ_d.pend = occ_d.pend + 1'b1;
            end
            if (occ_q.capture && sync_now) begin
                occ_d.capture = 1'b0;
                occ_d.pend    = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) occ_q <= '0;
        else        occ_q <= occ_d;
    end

    assign wr_addr = occ_q.tail;
    assign rd_addr = occ_q.head;
    assign vis_cnt = occ_q.total - occ_q.pend;

    // R9
    flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_rst |=> (vis_cnt == '0));

    // R8
    unsync_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_valid && !blk_insync && !keep_unsync && !occ_q.capture && !sync_rst && !pop)
        |=> $stable(vis_cnt));

    // R10
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_valid && blk_insync && !sync_rst && !pop && !occ_q.capture &&
         vis_cnt == CW'(DEPTH)) |=> (vis_cnt == CW'(DEPTH)));

endmodule

// File: rtl/blkbuf_reader.sv
module blkbuf_reader
    import blkbuf_pkg::*;
#(
    parameter int CW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_cs,
    input  logic              rd_shift,
    input  logic              flush,
    input  logic              head_drop,
    input  blk_t              head_blk,
    input  logic [CW-1:0]     vis_cnt,
    output logic              pop,
    output logic [WORD_W-1:0] rd_word,
    output logic              rd_bit
);

    localparam int BW = $clog2(WORD_W);
    localparam logic [BW-1:0] LAST_BIT = BW'(WORD_W - 1);

    typedef struct packed {
        logic [BW-1:0]     bitn;
        logic [WORD_W-1:0] snap;
        logic              snapv;
        logic              lost;
        logic              cs_prev;
    } rd_t;

    rd_t rd_d, rd_q;
    logic [WORD_W-1:0] live;
    logic fall, go, last;

    always_comb begin
        live = build_word(head_blk, 32'(vis_cnt));
        fall = rd_q.cs_prev && !rd_cs;
        go   = rd_cs && rd_shift;
        last = (rd_q.bitn == LAST_BIT);
        pop  = !flush && rd_q.snapv && !rd_q.lost && last && (go || fall);

        rd_d         = rd_q;
        rd_d.cs_prev = rd_cs;
        if (flush) begin
            rd_d.bitn  = '0;
            rd_d.snapv = 1'b0;
            rd_d.lost  = 1'b0;
        end else begin
            if (go) begin
                if (rd_q.bitn == '0) begin
                    rd_d.snap  = live;
                    rd_d.snapv = (vis_cnt != '0);
                    rd_d.lost  = 1'b0;
                end
                rd_d.bitn = last ? '0 : rd_q.bitn + 1'b1;
            end else if (fall) begin
                rd_d.bitn = '0;
            end
            if (head_drop) rd_d.lost = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rd_word = (rd_q.bitn == '0) ? live : rd_q.snap;
    assign rd_bit  = rd_word[LAST_BIT - rd_q.bitn];

    // R2
    pattern_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_word != '0) |-> (rd_word[3:0] == 4'b1010));

    // R6
    pop_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (vis_cnt != '0));

    // R5
    word_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_cs && !rd_shift && rd_q.bitn != '0 && !flush) |=> $stable(rd_word));

endmodule

// File: rtl/blkbuf_reqline.sv
module blkbuf_reqline #(
    parameter int HOLD_CYC = 13250,
    parameter int CW       = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_cs,
    input  logic [CW-1:0] vis_cnt,
    output logic          req_n
);

    localparam int HW = $clog2(HOLD_CYC + 1);

    typedef struct packed {
        logic [HW-1:0] hold;
        logic          cs_prev;
        logic          req_n;
    } rq_t;

    rq_t rq_d, rq_q;

    always_comb begin
        rq_d         = rq_q;
        rq_d.cs_prev = rd_cs;
        if (rq_q.cs_prev && !rd_cs)  rq_d.hold = HW'(HOLD_CYC);
        else if (rq_q.hold != '0)    rq_d.hold = rq_q.hold - 1'b1;
        rq_d.req_n = !((vis_cnt != '0) && (rq_d.hold == '0) && !rd_cs);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rq_q <= '{hold: '0, cs_prev: 1'b0, req_n: 1'b1};
        else        rq_q <= rq_d;
    end

    assign req_n = rq_q.req_n;

    // R7
    holdoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_cs) |=> req_n);

    // R7
    busy_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_cs |=> req_n);

    // R7
    req_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_n |-> ($past(vis_cnt) != '0));

endmodule

// File: rtl/blkbuf_top.sv
module blkbuf_top
    import blkbuf_pkg::*;
#(
    parameter int DEPTH    = 24,
    parameter int HOLD_CYC = 13250
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        blk_valid,
    input  logic [15:0] blk_data,
    input  logic [2:0]  blk_err,
    input  logic        blk_insync,
    input  logic        blk_tone,
    input  logic [2:0]  blk_otype,
    input  logic        blk_odet,
    input  logic        keep_unsync,
    input  logic        sync_rst,
    input  logic        sync_now,
    input  logic        rd_cs,
    input  logic        rd_shift,
    output logic [31:0] rd_word,
    output logic        rd_bit,
    output logic        req_n
);

    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    blk_t          in_blk, head_blk;
    logic          wr_en, pop, head_drop;
    logic [AW-1:0] wr_addr, rd_addr;
    logic [CW-1:0] vis_cnt;

    assign in_blk = '{data: blk_data, err: blk_err, insync: blk_insync,
                      tone: blk_tone, otype: blk_otype, odet: blk_odet};

    blkbuf_occ #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) occ_i (
        .clk(clk), .rst_n(rst_n), .blk_valid(blk_valid), .blk_insync(blk_insync),
        .keep_unsync(keep_unsync), .sync_rst(sync_rst), .sync_now(sync_now),
        .pop(pop), .wr_en(wr_en), .wr_addr(wr_addr), .rd_addr(rd_addr),
        .vis_cnt(vis_cnt), .head_drop(head_drop)
    );

    blkbuf_store #(.DEPTH(DEPTH), .AW(AW)) store_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_blk(in_blk), .rd_addr(rd_addr), .rd_blk(head_blk)
    );

    blkbuf_reader #(.CW(CW)) reader_i (
        .clk(clk), .rst_n(rst_n), .rd_cs(rd_cs), .rd_shift(rd_shift),
        .flush(sync_rst), .head_drop(head_drop), .head_blk(head_blk),
        .vis_cnt(vis_cnt), .pop(pop), .rd_word(rd_word), .rd_bit(rd_bit)
    );

    blkbuf_reqline #(.HOLD_CYC(HOLD_CYC), .CW(CW)) reqline_i (
        .clk(clk), .rst_n(rst_n), .rd_cs(rd_cs), .vis_cnt(vis_cnt), .req_n(req_n)
    );

endmodule

// File: tb/blkbuf_top_tb_top.sv
module blkbuf_top_tb_top;

    localparam int DEPTH = 24;
    localparam int HOLD  = 40;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        blk_valid = 0, blk_insync = 0, blk_tone = 0, blk_odet = 0;
    logic [15:0] blk_data = '0;
    logic [2:0]  blk_err = '0, blk_otype = '0;
    logic        keep_unsync = 0, sync_rst = 0, sync_now = 0, rd_cs = 0, rd_shift = 0;
    logic [31:0] rd_word;
    logic        rd_bit, req_n;

    blkbuf_top #(.DEPTH(DEPTH), .HOLD_CYC(HOLD)) dut_i (
        .clk(clk), .rst_n(rst_n), .blk_valid(blk_valid), .blk_data(blk_data),
        .blk_err(blk_err), .blk_insync(blk_insync), .blk_tone(blk_tone),
        .blk_otype(blk_otype), .blk_odet(blk_odet), .keep_unsync(keep_unsync),
        .sync_rst(sync_rst), .sync_now(sync_now), .rd_cs(rd_cs), .rd_shift(rd_shift),
        .rd_word(rd_word), .rd_bit(rd_bit), .req_n(req_n)
    );

    int checks = 0, fails = 0;
    string tag = "R11";
    bit done = 0;

    // ---------------- behavioural reference ----------------
    logic [24:0] mq[$];
    int m_pend, m_bit, m_hold;
    bit m_cap, m_snapv, m_lost, m_csq, m_req_n = 1;
    logic [31:0] m_snap;
    int t_vis;
    logic [31:0] t_live;
    bit t_fall, t_pop, t_dropv;

    function automatic logic [31:0] live_word();
        int vis, f;
        logic [24:0] e;
        vis = mq.size() - m_pend;
        if (vis <= 0) return 32'h0;
        e = mq[0];
        f = vis / 8;
        if (f > 3) f = 3;
        return {e[24:9], e[8:6], e[5], e[4], 2'(f), (vis >= 2) ? 1'b1 : 1'b0,
                e[3:1], e[0], 4'b1010};
    endfunction

    function automatic logic [31:0] exp_word();
        return (m_bit == 0) ? live_word() : m_snap;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            mq.delete(); m_pend = 0; m_cap = 0; m_bit = 0; m_snap = 0;
            m_snapv = 0; m_lost = 0; m_csq = 0; m_hold = 0; m_req_n = 1;
        end else begin
            t_vis = mq.size() - m_pend;
            t_live = live_word();
            t_fall = m_csq && !rd_cs;
            t_pop = 0; t_dropv = 0;
            if (sync_rst) begin
                mq.delete(); m_pend = 0; m_cap = 1; m_bit = 0; m_snapv = 0; m_lost = 0;
            end else begin
                if (rd_cs && rd_shift) begin
                    if (m_bit == 0) begin m_snap = t_live; m_snapv = (t_vis > 0); m_lost = 0; end
                    if (m_bit == 31) begin t_pop = m_snapv && !m_lost; m_bit = 0; end
                    else m_bit++;
                end else if (t_fall) begin
                    if (m_bit == 31) t_pop = m_snapv && !m_lost;
                    m_bit = 0;
                end
                if (t_pop) void'(mq.pop_front());
                if (blk_valid && (m_cap || blk_insync || keep_unsync)) begin
                    if (mq.size() == DEPTH) begin
                        if (mq.size() - m_pend > 0) t_dropv = 1; else m_pend--;
                        void'(mq.pop_front());
                    end
                    mq.push_back({blk_data, blk_err, blk_insync, blk_tone, blk_otype, blk_odet});
                    if (m_cap) m_pend++;
                end
                if (t_dropv) m_lost = 1;
                if (m_cap && sync_now) begin m_cap = 0; m_pend = 0; end
            end
            if (t_fall) m_hold = HOLD; else if (m_hold > 0) m_hold--;
            m_req_n = !(t_vis > 0 && m_hold == 0 && !rd_cs);
            m_csq = rd_cs;
        end
    end

    // cycle compare against the reference
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [31:0] ew;
            ew = exp_word();
            checks++;
            if (rd_word !== ew || rd_bit !== ew[31 - m_bit] || req_n !== m_req_n) begin
                fails++;
                $display("FAIL %s cycle: word=%h bit=%b req_n=%b expected word=%h bit=%b req_n=%b",
                         tag, rd_word, rd_bit, req_n, ew, ew[31 - m_bit], m_req_n);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic tick();
        @(posedge clk); #2;
    endtask

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s directed: actual=%h expected=%h", r, act, exp);
        end
    endtask

    task automatic put(input logic [15:0] d, input logic [2:0] e, input logic s,
                       input logic t, input logic [2:0] o, input logic od);
        blk_data = d; blk_err = e; blk_insync = s; blk_tone = t;
        blk_otype = o; blk_odet = od; blk_valid = 1;
        tick();
        blk_valid = 0;
    endtask

    task automatic shift_n(input int n);
        rd_cs = 1; rd_shift = 1;
        repeat (n) tick();
        rd_shift = 0;
    endtask

    task automatic end_read();
        rd_cs = 0; tick();
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        @(negedge clk);
        // R11 reset state
        chk("R11", rd_word, 32'h0);
        chk("R11", {31'h0, req_n}, 32'h1);
        tick();

        // R2 R3 single block layout
        tag = "R2";
        put(16'hBEEF, 3'd2, 1, 0, 3'd3, 1);
        tick();
        @(negedge clk);
        chk("R2", rd_word, {16'hBEEF, 3'b010, 1'b1, 1'b0, 2'b00, 1'b0, 3'b011, 1'b1, 4'b1010});
        chk("R7", {31'h0, req_n}, 32'h0);

        // R4 read it, then keep reading an empty store
        tag = "R4";
        shift_n(32);
        @(negedge clk);
        chk("R4", rd_word, 32'h0);
        shift_n(64);
        @(negedge clk);
        chk("R4", rd_word, 32'h0);
        end_read();
        repeat (HOLD + 2) tick();

        // R8 write filter
        tag = "R8";
        keep_unsync = 0;
        put(16'h5555, 3'd0, 0, 1, 3'd1, 1);
        tick();
        @(negedge clk);
        chk("R8", rd_word, 32'h0);
        chk("R8", {31'h0, req_n}, 32'h1);
        keep_unsync = 1;
        put(16'h1234, 3'd6, 0, 1, 3'd4, 0);
        tick();
        @(negedge clk);
        chk("R8", {16'h0, rd_word[31:16]}, 32'h1234);
        chk("R8", {31'h0, rd_word[12]}, 32'h0);

        // R5 interrupted reads
        tag = "R5";
        shift_n(10);
        tick();
        @(negedge clk);
        chk("R5", {16'h0, rd_word[31:16]}, 32'h1234);
        end_read();
        @(negedge clk);
        chk("R5", {16'h0, rd_word[31:16]}, 32'h1234);
        shift_n(31);
        end_read();
        @(negedge clk);
        chk("R5", rd_word, 32'h0);
        repeat (HOLD + 2) tick();

        // R6 R1 continuous multi-block readout
        tag = "R6";
        keep_unsync = 0;
        put(16'hA001, 3'd0, 1, 0, 3'd0, 1);
        put(16'hA002, 3'd1, 1, 0, 3'd1, 1);
        put(16'hA003, 3'd5, 1, 1, 3'd2, 1);
        @(negedge clk);
        chk("R3", {29'h0, rd_word[10:8]}, 32'h1);
        chk("R1", {16'h0, rd_word[31:16]}, 32'hA001);
        shift_n(32);
        @(negedge clk);
        chk("R6", {16'h0, rd_word[31:16]}, 32'hA002);
        shift_n(32);
        @(negedge clk);
        chk("R6", {16'h0, rd_word[31:16]}, 32'hA003);
        chk("R3", {31'h0, rd_word[8]}, 32'h0);
        shift_n(32);
        end_read();
        @(negedge clk);
        chk("R6", rd_word, 32'h0);
        repeat (HOLD + 2) tick();

        // R7 hold-off after a read with data left
        tag = "R7";
        put(16'hB001, 3'd0, 1, 0, 3'd0, 0);
        put(16'hB002, 3'd0, 1, 0, 3'd0, 0);
        tick();
        shift_n(32);
        rd_cs = 0;
        tick();
        repeat (HOLD - 1) tick();
        @(negedge clk);
        chk("R7", {31'h0, req_n}, 32'h1);
        tick();
        @(negedge clk);
        chk("R7", {31'h0, req_n}, 32'h0);

        // R9 sync reset and capture
        tag = "R9";
        sync_rst = 1; tick(); sync_rst = 0; tick();
        @(negedge clk);
        chk("R9", rd_word, 32'h0);
        chk("R9", {31'h0, req_n}, 32'h1);
        put(16'hC001, 3'd3, 0, 0, 3'd1, 0);
        put(16'hC002, 3'd4, 0, 0, 3'd2, 1);
        tick(); tick();
        @(negedge clk);
        chk("R9", rd_word, 32'h0);
        chk("R9", {31'h0, req_n}, 32'h1);
        sync_now = 1; tick(); sync_now = 0; tick();
        @(negedge clk);
        chk("R9", {13'h0, rd_word[31:16], rd_word[10:8]}, {13'h0, 16'hC001, 3'b001});
        chk("R9", {31'h0, req_n}, 32'h0);

        // R10 overwrite when full (2 held + 26 new -> 4 oldest gone)
        tag = "R10";
        for (int i = 0; i < 26; i++) put(16'h0100 + 16'(i), 3'd0, 1, 0, 3'(i), 1);
        tick();
        @(negedge clk);
        chk("R10", {16'h0, rd_word[31:16]}, 32'h0102);
        chk("R3", {29'h0, rd_word[10:8]}, 32'h7);
        shift_n(32);
        @(negedge clk);
        chk("R10", {16'h0, rd_word[31:16]}, 32'h0103);
        chk("R3", {30'h0, rd_word[10:9]}, 32'h2);
        // overwrite of the word being delivered
        shift_n(5);
        put(16'hD000, 3'd0, 1, 0, 3'd0, 0);
        put(16'hD001, 3'd0, 1, 0, 3'd0, 0);
        shift_n(27);
        end_read();
        @(negedge clk);
        chk("R10", {16'h0, rd_word[31:16]}, 32'h0104);
        repeat (4) tick();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule